// File: doc/BRIEF.md
# E1 Line Transmit Encoder (HDB3 / AMI)

This block converts one channel of E1 transmit data into a pair of rail pulse outputs, one positive and one negative. NRZ data is sampled with a transmit bit clock. That bit clock does not drive any flop directly: the block runs on a fast system clock, synchronises the bit clock and finds its edges by oversampling. Each accepted bit updates the rails, and `bit_stb` pulses for one system cycle to mark the update.

The rails can be produced in five ways, listed here from highest to lowest priority:

1. Remote-loop rails pass through unchanged.
2. A continuous all-ones pattern is sent.
3. Dual-rail inputs pass through unchanged.
4. Plain alternate-mark coding is applied.
5. HDB3 coding is applied, with zero-run substitution.

A supervisor counts system cycles since the last bit clock edge. When the bit clock stays still for longer than a programmed count, all-ones transmission is paced by an external reference tick instead.

The design has three state machines:

- **Clock supervisor** (`CLK_OK`, `CLK_LOST`). It moves from `CLK_OK` to `CLK_LOST` when the idle count reaches `timeout_cycles` and no edge is seen. It moves back to `CLK_OK` on any bit clock edge.
- **HDB3 zero-run tracker** (`RUN0` to `RUN3`). Each zero input steps it one state forward. A one input returns it to `RUN0`. A zero input while in `RUN3` triggers a substitution and also returns it to `RUN0`.
- **Output path select** (`PATH_LOOP`, `PATH_ONES`, `PATH_DUAL`, `PATH_AMI`, `PATH_HDB3`). This is a combinational choice made from the mode inputs, using the priority order above.

Top module: `e1_line_encoder`

## Requirements
- R1: After reset, `pos_out`, `neg_out`, `bit_stb` and `fallback` are all 0.
- R2: When `sample_rise`=1, a rising bit clock edge accepts a bit; when it is 0, a falling edge does. Each accepted bit updates the rails and raises `bit_stb` for exactly one system cycle; the rails are held between bits.
- R3: With `ami_sel`=1, each 1 on `tx_pos` gives a pulse of opposite polarity to the previous pulse, and each 0 gives no pulse (both rails 0), in the same bit. The first pulse after reset is positive (`pos_out`=1, `neg_out`=0).
- R4: With `ami_sel`=0, HDB3 output for a bit appears four accepted bits after that bit enters; the first four outputs after reset are spaces. Marks alternate polarity.
- R5: In HDB3, every run of four zeros is replaced. If an even number of pulses (including zero pulses) has been sent since the last violation, the run becomes B00V; if the number is odd, it becomes 000V. B takes the alternating polarity; V repeats the polarity of the pulse before it. The count starts even at reset.
- R6: In single-rail modes (`dual_rail`=0), `tx_neg` has no effect on the rails.
- R7: With `dual_rail`=1, the rails show the sampled `tx_pos` and `tx_neg` unchanged.
- R8: With `all_ones`=1, every accepted bit is a pulse of alternating polarity, whatever the data inputs are.
- R9: `fallback` rises after `timeout_cycles` system cycles with no bit clock edge and clears after the next edge. While it is set and all-ones is active, each `ref_tick` pulse also accepts a bit.
- R10: `remote_loop`=1 takes priority over `all_ones`: the rails show the sampled `loop_pos` and `loop_neg`.
- R11: In coded modes, the two rails are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_clk_in | input | 1 | Transmit bit clock, oversampled |
| ref_tick | input | 1 | Fallback reference pulse, one system cycle wide |
| tx_pos | input | 1 | NRZ data (single rail) or positive rail input (dual rail) |
| tx_neg | input | 1 | Negative rail input, used in dual rail only |
| sample_rise | input | 1 | 1 = sample on the rising edge, 0 = sample on the falling edge |
| dual_rail | input | 1 | 1 = pass the rails through uncoded |
| ami_sel | input | 1 | 1 = AMI coding, 0 = HDB3 coding |
| all_ones | input | 1 | Transmit the all-ones pattern |
| remote_loop | input | 1 | Send the loop rails; overrides all-ones |
| loop_pos | input | 1 | Looped positive rail |
| loop_neg | input | 1 | Looped negative rail |
| timeout_cycles | input | 16 | Idle system cycles before the fallback engages |
| pos_out | output | 1 | Positive rail pulse |
| neg_out | output | 1 | Negative rail pulse |
| bit_stb | output | 1 | Marks the cycle in which the rails change |
| fallback | output | 1 | The bit clock has been declared lost |

## Verification
A sampling edge on `tx_clk_in` takes two synchroniser cycles and one output-register cycle. So the rails and `bit_stb` change on the third system clock after the edge is captured, roughly four cycles after the edge itself. A `ref_tick` pulse in fallback updates the rails one cycle later.

HDB3 adds a further four accepted bits of delay. The bench's model therefore starts with four spaces queued and releases one expected symbol for every bit it drives.

The scoreboard never waits a fixed number of cycles. It compares each queued expectation at the first falling clock edge on which `bit_stb` is high. The counts of strobes and expectations must match exactly, and each driver holds the data for eight system cycles around the sampling edge.

// File: rtl/e1_enc_pkg.sv
package e1_enc_pkg;
    typedef enum logic [1:0] {
        SYM_SPACE = 2'd0,
        SYM_MARK  = 2'd1,
        SYM_BAL   = 2'd2,
        SYM_VIOL  = 2'd3
    } sym_t;

    typedef enum logic {
        CLK_OK,
        CLK_LOST
    } clk_state_t;

    typedef enum logic [1:0] {
        RUN0,
        RUN1,
        RUN2,
        RUN3
    } run_state_t;

    typedef enum logic [2:0] {
        PATH_LOOP,
        PATH_ONES,
        PATH_DUAL,
        PATH_AMI,
        PATH_HDB3
    } path_t;
endpackage

// File: rtl/e1_txclk_monitor.sv
module e1_txclk_monitor
    import e1_enc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_clk_in,
    input  logic             sample_rise,
    input  logic [CNT_W-1:0] timeout_cycles,
    output logic             sample_ev,
    output logic             any_edge,
    output logic             fallback
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0]  sync_q;
    logic [CNT_W-1:0] idle_q;
    logic             rise;
    logic             fall;
    clk_state_t       st_q;
    clk_state_t       st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SH_W-2:0], tx_clk_in};
        end
    end

    assign rise      = sync_q[SH_W-2] & ~sync_q[SH_W-1];
    assign fall      = ~sync_q[SH_W-2] & sync_q[SH_W-1];
    assign any_edge  = rise | fall;
    assign sample_ev = sample_rise ? rise : fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_q <= '0;
        end else if (any_edge) begin
            idle_q <= '0;
        end else if (idle_q != {CNT_W{1'b1}}) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CLK_OK;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CLK_OK:   if (!any_edge && idle_q >= timeout_cycles) st_d = CLK_LOST;
            CLK_LOST: if (any_edge) st_d = CLK_OK;
        endcase
    end

    assign fallback = (st_q == CLK_LOST);

    assert_edge_restores_R9: assert property (@(posedge clk) disable iff (!rst_n)
        any_edge |=> !fallback);

    assert_lost_needs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fallback) |-> !$past(any_edge));
endmodule

// File: rtl/e1_hdb3_core.sv
module e1_hdb3_core
    import e1_enc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    input  logic bit_in,
    output sym_t sym_out
);
    sym_t       line_q [DEPTH];
    run_state_t run_q;
    run_state_t run_d;
    logic       par_q;
    logic       subst;

    assign subst   = advance && !bit_in && (run_q == RUN3);
    assign sym_out = line_q[DEPTH-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= RUN0;
        end else begin
            run_q <= run_d;
        end
    end

    always_comb begin
        run_d = run_q;
        if (advance) begin
            unique case (run_q)
                RUN0: run_d = bit_in ? RUN0 : RUN1;
                RUN1: run_d = bit_in ? RUN0 : RUN2;
                RUN2: run_d = bit_in ? RUN0 : RUN3;
                RUN3: run_d = RUN0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) line_q[i] <= SYM_SPACE;
            par_q <= 1'b0;
        end else if (advance) begin
            line_q[0] <= subst ? SYM_VIOL : (bit_in ? SYM_MARK : SYM_SPACE);
            for (int i = 1; i < DEPTH - 1; i++) line_q[i] <= line_q[i-1];
            line_q[DEPTH-1] <= (subst && !par_q) ? SYM_BAL : line_q[DEPTH-2];
            par_q <= subst ? 1'b0 : (par_q ^ bit_in);
        end
    end

    assert_one_clears_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && bit_in) |=> (run_q == RUN0));

    assert_fourth_zero_viol_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !bit_in && run_q == RUN3) |=> (line_q[0] == SYM_VIOL));
endmodule

// File: rtl/e1_line_encoder.sv
module e1_line_encoder
    import e1_enc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_clk_in,
    input  logic             ref_tick,
    input  logic             tx_pos,
    input  logic             tx_neg,
    input  logic             sample_rise,
    input  logic             dual_rail,
    input  logic             ami_sel,
    input  logic             all_ones,
    input  logic             remote_loop,
    input  logic             loop_pos,
    input  logic             loop_neg,
    input  logic [CNT_W-1:0] timeout_cycles,
    output logic             pos_out,
    output logic             neg_out,
    output logic             bit_stb,
    output logic             fallback
);
    logic  sample_ev;
    logic  any_edge;
    logic  ev;
    logic  taos_act;
    logic  hdb3_adv;
    path_t path;
    sym_t  hdb3_sym;
    sym_t  sym_d;
    logic  pos_d, neg_d, last_d, coded_d;
    logic  pos_q, neg_q, stb_q, last_pos_q, coded_q;

    e1_txclk_monitor #(.CNT_W(CNT_W)) mon_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_clk_in      (tx_clk_in),
        .sample_rise    (sample_rise),
        .timeout_cycles (timeout_cycles),
        .sample_ev      (sample_ev),
        .any_edge       (any_edge),
        .fallback       (fallback)
    );

    assign taos_act = all_ones & ~remote_loop;
    assign ev       = sample_ev | (fallback & ref_tick & taos_act);

    always_comb begin
        if (remote_loop)    path = PATH_LOOP;
        else if (all_ones)  path = PATH_ONES;
        else if (dual_rail) path = PATH_DUAL;
        else if (ami_sel)   path = PATH_AMI;
        else                path = PATH_HDB3;
    end

    assign hdb3_adv = ev && (path == PATH_HDB3);

    e1_hdb3_core #(.DEPTH(4)) core_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (hdb3_adv),
        .bit_in  (tx_pos),
        .sym_out (hdb3_sym)
    );

    always_comb begin
        sym_d   = SYM_SPACE;
        pos_d   = 1'b0;
        neg_d   = 1'b0;
        last_d  = last_pos_q;
        coded_d = 1'b1;
        unique case (path)
            PATH_LOOP: begin pos_d = loop_pos; neg_d = loop_neg; coded_d = 1'b0; end
            PATH_DUAL: begin pos_d = tx_pos;   neg_d = tx_neg;   coded_d = 1'b0; end
            PATH_ONES: sym_d = SYM_MARK;
            PATH_AMI:  sym_d = tx_pos ? SYM_MARK : SYM_SPACE;
            PATH_HDB3: sym_d = hdb3_sym;
            default:   sym_d = SYM_SPACE;
        endcase
        if (coded_d) begin
            unique case (sym_d)
                SYM_SPACE: begin pos_d = 1'b0; neg_d = 1'b0; end
                SYM_MARK, SYM_BAL: begin
                    last_d = ~last_pos_q;
                    pos_d  = ~last_pos_q;
                    neg_d  = last_pos_q;
                end
                SYM_VIOL: begin pos_d = last_pos_q; neg_d = ~last_pos_q; end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q      <= 1'b0;
            neg_q      <= 1'b0;
            stb_q      <= 1'b0;
            last_pos_q <= 1'b0;
            coded_q    <= 1'b0;
        end else begin
            stb_q <= ev;
            if (ev) begin
                pos_q      <= pos_d;
                neg_q      <= neg_d;
                last_pos_q <= last_d;
                coded_q    <= coded_d;
            end
        end
    end

    assign pos_out = pos_q;
    assign neg_out = neg_q;
    assign bit_stb = stb_q;

    assert_rails_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        coded_q |-> !(pos_q && neg_q));

    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> bit_stb);

    assert_rails_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ev |=> (!bit_stb && $stable(pos_out) && $stable(neg_out)));
endmodule

// File: tb/e1_line_encoder_tb_top.sv
module e1_line_encoder_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_clk_in = 1'b0, ref_tick = 1'b0, tx_pos = 1'b0, tx_neg = 1'b0;
    logic sample_rise = 1'b1, dual_rail = 1'b0, ami_sel = 1'b1, all_ones = 1'b0;
    logic remote_loop = 1'b0, loop_pos = 1'b0, loop_neg = 1'b0;
    logic [15:0] timeout_cycles = 16'd40;
    logic pos_out, neg_out, bit_stb, fallback;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    // bench model state
    logic m_last_pos;
    logic m_par;
    int   m_run;
    int   m_line[$];

    always #2 clk = ~clk;

    e1_line_encoder dut_i (
        .clk(clk), .rst_n(rst_n), .tx_clk_in(tx_clk_in), .ref_tick(ref_tick),
        .tx_pos(tx_pos), .tx_neg(tx_neg), .sample_rise(sample_rise),
        .dual_rail(dual_rail), .ami_sel(ami_sel), .all_ones(all_ones),
        .remote_loop(remote_loop), .loop_pos(loop_pos), .loop_neg(loop_neg),
        .timeout_cycles(timeout_cycles), .pos_out(pos_out), .neg_out(neg_out),
        .bit_stb(bit_stb), .fallback(fallback)
    );

    task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && bit_stb) begin
            if (exp_q.size() == 0) begin
                chk("R2", {2'b00, pos_out, neg_out}, 4'b1111);
            end else begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, {2'b00, pos_out, neg_out}, {2'b00, e});
                if (t != "R7" && t != "R10")
                    chk("R11", {3'b000, pos_out & neg_out}, 4'b0000);
            end
        end
    end

    task automatic push_raw(logic p, logic n, string t);
        exp_q.push_back({p, n});
        tag_q.push_back(t);
    endtask

    task automatic push_sym(int s, string t);
        case (s)
            1, 2: begin m_last_pos = ~m_last_pos; push_raw(m_last_pos, ~m_last_pos, t); end
            3:    push_raw(m_last_pos, ~m_last_pos, t);
            default: push_raw(1'b0, 1'b0, t);
        endcase
    endtask

    task automatic model_reset();
        m_last_pos = 1'b0;
        m_par = 1'b0;
        m_run = 0;
        m_line = {0, 0, 0, 0};
    endtask

    task automatic model_hdb3(logic b);
        int s;
        s = m_line.pop_front();
        push_sym(s, (s >= 2) ? "R5" : "R4");
        if (b) begin
            m_line.push_back(1);
            m_par = ~m_par;
            m_run = 0;
        end else if (m_run == 3) begin
            if (!m_par) m_line[0] = 2;
            m_line.push_back(3);
            m_par = 1'b0;
            m_run = 0;
        end else begin
            m_line.push_back(0);
            m_run++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        tx_clk_in = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        repeat (6) @(negedge clk);
    endtask

    task automatic edge_pre(logic d, logic n, logic lp, logic ln);
        @(negedge clk);
        tx_pos = d; tx_neg = n; loop_pos = lp; loop_neg = ln;
        tx_clk_in = ~sample_rise;
        repeat (8) @(negedge clk);
    endtask

    task automatic edge_fire();
        tx_clk_in = sample_rise;
        repeat (8) @(negedge clk);
    endtask

    task automatic ami_bit(logic b, logic n, string t);
        edge_pre(b, n, 1'b0, 1'b0);
        push_sym(b ? 1 : 0, t);
        edge_fire();
    endtask

    task automatic hdb3_bit(logic b);
        edge_pre(b, $urandom_range(0, 1), 1'b0, 1'b0);
        model_hdb3(b);
        edge_fire();
    endtask

    task automatic dual_bit(logic p, logic n);
        edge_pre(p, n, 1'b0, 1'b0);
        push_raw(p, n, "R7");
        edge_fire();
    endtask

    task automatic ones_bit(logic d, logic n);
        edge_pre(d, n, 1'b0, 1'b0);
        push_sym(1, "R8");
        edge_fire();
    endtask

    task automatic loop_bit(logic lp, logic ln);
        edge_pre($urandom_range(0, 1), $urandom_range(0, 1), lp, ln);
        push_raw(lp, ln, "R10");
        edge_fire();
    endtask

    task automatic drain();
        repeat (10) @(negedge clk);
        chk("R2", {3'b000, exp_q.size() == 0}, 4'b0001);
        exp_q.delete();
        tag_q.delete();
    endtask

    initial begin
        logic [19:0] hpat;
        model_reset();
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", {pos_out, neg_out, bit_stb, fallback}, 4'b0000);
        do_reset();
        chk("R1", {pos_out, neg_out, bit_stb, fallback}, 4'b0000);

        // R3 AMI on rising edge, R6 tx_neg ignored
        ami_sel = 1'b1; sample_rise = 1'b1;
        ami_bit(1, 0, "R3"); ami_bit(0, 1, "R3"); ami_bit(1, 1, "R3");
        ami_bit(1, 0, "R3"); ami_bit(0, 0, "R3"); ami_bit(1, 1, "R3");
        ami_bit(0, 1, "R6"); ami_bit(0, 1, "R6");
        drain();

        // R2 falling-edge sampling
        sample_rise = 1'b0;
        ami_bit(1, 0, "R2"); ami_bit(0, 0, "R2"); ami_bit(1, 1, "R2"); ami_bit(1, 0, "R2");
        drain();

        // R4/R5 HDB3
        sample_rise = 1'b1; ami_sel = 1'b0;
        do_reset();
        hpat = 20'b0000_1100_0000_0010_0001;
        for (int i = 0; i < 20; i++) hdb3_bit(hpat[i]);
        for (int i = 0; i < 8; i++) hdb3_bit(1'b0);
        hdb3_bit(1'b1); hdb3_bit(1'b1); hdb3_bit(1'b1);
        for (int i = 0; i < 9; i++) hdb3_bit(1'b0);
        drain();

        // R7 dual rail
        dual_rail = 1'b1;
        do_reset();
        dual_bit(1, 0); dual_bit(0, 1); dual_bit(1, 1); dual_bit(0, 0);
        drain();

        // R8 all-ones ignores data
        all_ones = 1'b1;
        do_reset();
        ones_bit(0, 0); ones_bit(0, 1); ones_bit(1, 1); ones_bit(0, 0);
        drain();

        // R10 loopback priority over all-ones
        remote_loop = 1'b1;
        do_reset();
        loop_bit(1, 0); loop_bit(0, 1); loop_bit(0, 0); loop_bit(1, 1);
        drain();

        // R9 fallback to reference tick
        remote_loop = 1'b0; dual_rail = 1'b0; sample_rise = 1'b0;
        do_reset();
        ones_bit(0, 0); ones_bit(1, 0);
        tx_clk_in = 1'b1;
        repeat (20) @(negedge clk);
        chk("R9", {3'b000, fallback}, 4'b0000);
        repeat (40) @(negedge clk);
        chk("R9", {3'b000, fallback}, 4'b0001);
        for (int k = 0; k < 3; k++) begin
            push_sym(1, "R9");
            ref_tick = 1'b1;
            @(negedge clk);
            ref_tick = 1'b0;
            repeat (10) @(negedge clk);
        end
        ones_bit(0, 0);
        chk("R9", {3'b000, fallback}, 4'b0000);
        drain();

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule